// File: doc/BRIEF.md
# Six-Pin GPIO Owner Multiplexer

This block controls six bidirectional pins that sit behind one bus address. A control word written at that address does one of two things. It can set the direction and the output level of each pin directly from software. It can also hand all six pins, as a group, to one of three auxiliary logic sources. Each source drives its own 6-bit direction bus and its own 6-bit value bus. A read at the same address returns the level the six pins actually carry, after a two-flop synchronizer, whatever mode is selected.

The pin owner is held as a four-state register: `OWN_SW`, `OWN_SRC_A`, `OWN_SRC_B` and `OWN_SRC_C`. A write to the control address is the only transition. From any state it moves to the state encoded in bits [13:12] of the written word, and that includes moving back into the current state. Reset forces `OWN_SW`. The block does not contain the pad cells. It outputs a per-pin output enable and per-pin output data, and it takes in the raw pin levels.

Top module: `gpio_owner_mux`

## Requirements
- R1: After reset the stored control word is zero. The owner is `OWN_SW`, and `pad_oe` and `pad_out` are both all zeros.
- R2: A write with `bus_wr` high and `bus_addr` equal to 0x70 stores bits [13:0] of `bus_wdata` at that clock edge. A write to any other address leaves the stored word and the pin outputs unchanged.
- R3: Stored bits [13:12] select the owner. 0 selects software, 1 selects source A (`src_dir[5:0]`/`src_val[5:0]`), 2 selects source B (bits [11:6]) and 3 selects source C (bits [17:12]).
- R4: Under software ownership, pin n takes its direction from stored bit 2n+1 (1 = output, 0 = input) and its output value from bit 2n.
- R5: Any pin whose `pad_oe` bit is 0 has its `pad_out` bit at 0, so the value bit is ignored for input pins in every mode.
- R6: Under a source's ownership, `pad_oe` follows that source's direction bus combinationally, and stored bits [11:0] have no effect on the pins.
- R7: Writing 0x000B gives `pad_oe` = 6'b000011 and `pad_out` = 6'b000001.
- R8: When `bus_addr` is 0x70, `rd_data` carries `pad_in` delayed by two clock edges, zero-extended to 16 bits, in any mode. At any other address `rd_data` is zero.
- R9: Bits [15:14] of `bus_wdata` are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Bus address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| rd_data | output | 16 | Read data: synchronized pin levels, zero-extended |
| src_dir | input | 18 | Direction buses of sources A, B, C (6 bits each, A lowest) |
| src_val | input | 18 | Value buses of sources A, B, C (6 bits each, A lowest) |
| pad_in | input | 6 | Raw pin levels |
| pad_oe | output | 6 | Per-pin output enable |
| pad_out | output | 6 | Per-pin output data |

## Verification
A wrong owner state shows at once. In the cycle after the write that caused it, `pad_oe` follows the wrong direction bus or the wrong software bit pairs. A corrupted bit pair appears in the same cycle as a pin driven in the wrong direction, or as a value that leaks onto a pin set as input. A fault in the synchronizer shows as `rd_data` changing one edge too early, or never changing, relative to `pad_in`.

// File: rtl/gpio_owner_pkg.sv
package gpio_owner_pkg;
    localparam int SEL_W   = 2;
    localparam int SRC_NUM = 3;

    typedef enum logic [SEL_W-1:0] {
        OWN_SW    = 2'd0,
        OWN_SRC_A = 2'd1,
        OWN_SRC_B = 2'd2,
        OWN_SRC_C = 2'd3
    } owner_e;
endpackage

// File: rtl/gpio_owner_ctrl.sv
module gpio_owner_ctrl
    import gpio_owner_pkg::*;
#(
    parameter int PIN_N     = 6,
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 16,
    parameter int CTRL_ADDR = 'h70
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_wr,
    input  logic [DATA_W-1:0]    bus_wdata,
    output owner_e               owner_q,
    output logic [2*PIN_N-1:0]   pairs_q
);
    localparam int PAIR_W = 2 * PIN_N;
    localparam int CTRL_W = PAIR_W + SEL_W;

    logic   wr_hit;
    owner_e owner_d;

    assign wr_hit = bus_wr && (bus_addr == ADDR_W'(CTRL_ADDR));

    generate
        if (DATA_W > CTRL_W) begin : g_hi
            logic unused_hi;
            assign unused_hi = ^bus_wdata[DATA_W-1:CTRL_W];
        end
    endgenerate

    // Next-state: any state moves to the owner named in the written field.
    always_comb begin
        owner_d = owner_q;
        if (wr_hit) begin
            unique case (bus_wdata[CTRL_W-1:PAIR_W])
                2'd0: owner_d = OWN_SW;
                2'd1: owner_d = OWN_SRC_A;
                2'd2: owner_d = OWN_SRC_B;
                2'd3: owner_d = OWN_SRC_C;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) owner_q <= OWN_SW;
        else        owner_q <= owner_d;
    end

    // Software pair bits
    always_ff @(posedge clk) begin
        if (!rst_n)      pairs_q <= '0;
        else if (wr_hit) pairs_q <= bus_wdata[PAIR_W-1:0];
    end

    AST_WRITE_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit |=> (pairs_q == $past(bus_wdata[PAIR_W-1:0])) &&
                   (owner_q == $past(bus_wdata[CTRL_W-1:PAIR_W]))); // R2
    AST_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_hit |=> $stable(pairs_q) && $stable(owner_q)); // R2
endmodule

// File: rtl/gpio_owner_route.sv
module gpio_owner_route
    import gpio_owner_pkg::*;
#(
    parameter int PIN_N = 6
) (
    input  owner_e                     owner_q,
    input  logic [2*PIN_N-1:0]         pairs_q,
    input  logic [SRC_NUM*PIN_N-1:0]   src_dir,
    input  logic [SRC_NUM*PIN_N-1:0]   src_val,
    output logic [PIN_N-1:0]           pad_oe,
    output logic [PIN_N-1:0]           pad_out
);
    logic [PIN_N-1:0] sw_dir, sw_val;
    logic [PIN_N-1:0] sel_dir, sel_val;

    for (genvar n = 0; n < PIN_N; n++) begin : g_pair
        assign sw_val[n] = pairs_q[2*n];
        assign sw_dir[n] = pairs_q[2*n+1];
    end

    // Output process: per-state selection of direction and value
    always_comb begin
        unique case (owner_q)
            OWN_SW: begin
                sel_dir = sw_dir;
                sel_val = sw_val;
            end
            OWN_SRC_A: begin
                sel_dir = src_dir[0*PIN_N +: PIN_N];
                sel_val = src_val[0*PIN_N +: PIN_N];
            end
            OWN_SRC_B: begin
                sel_dir = src_dir[1*PIN_N +: PIN_N];
                sel_val = src_val[1*PIN_N +: PIN_N];
            end
            OWN_SRC_C: begin
                sel_dir = src_dir[2*PIN_N +: PIN_N];
                sel_val = src_val[2*PIN_N +: PIN_N];
            end
        endcase
    end

    assign pad_oe  = sel_dir;
    assign pad_out = sel_dir & sel_val;
endmodule

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
    parameter int WIDTH = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] raw_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage1_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1_q <= '0;
            sync_out <= '0;
        end else begin
            stage1_q <= raw_in;
            sync_out <= stage1_q;
        end
    end
endmodule

// File: rtl/gpio_owner_mux.sv
module gpio_owner_mux
    import gpio_owner_pkg::*;
#(
    parameter int PIN_N     = 6,
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 16,
    parameter int CTRL_ADDR = 'h70
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [ADDR_W-1:0]           bus_addr,
    input  logic                        bus_wr,
    input  logic [DATA_W-1:0]           bus_wdata,
    output logic [DATA_W-1:0]           rd_data,
    input  logic [SRC_NUM*PIN_N-1:0]    src_dir,
    input  logic [SRC_NUM*PIN_N-1:0]    src_val,
    input  logic [PIN_N-1:0]            pad_in,
    output logic [PIN_N-1:0]            pad_oe,
    output logic [PIN_N-1:0]            pad_out
);
    localparam int PAD_W = DATA_W - PIN_N;

    owner_e             owner_q;
    logic [2*PIN_N-1:0] pairs_q;
    logic [PIN_N-1:0]   pin_sync;

    gpio_owner_ctrl #(
        .PIN_N(PIN_N), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_ADDR(CTRL_ADDR)
    ) ctrl_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .owner_q(owner_q), .pairs_q(pairs_q)
    );

    gpio_owner_route #(.PIN_N(PIN_N)) route_i (
        .owner_q(owner_q), .pairs_q(pairs_q), .src_dir(src_dir),
        .src_val(src_val), .pad_oe(pad_oe), .pad_out(pad_out)
    );

    gpio_pin_sync #(.WIDTH(PIN_N)) sync_i (
        .clk(clk), .rst_n(rst_n), .raw_in(pad_in), .sync_out(pin_sync)
    );

    assign rd_data = (bus_addr == ADDR_W'(CTRL_ADDR)) ?
                     {{PAD_W{1'b0}}, pin_sync} : '0;

    AST_OUT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_out & ~pad_oe) == '0); // R5
    AST_RD_ZERO_EXT: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[DATA_W-1:PIN_N] == '0); // R8
    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pad_oe == '0)); // R1
    AST_SW_ODD_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (owner_q == OWN_SW) |-> pad_oe[0] == pairs_q[1]); // R4
endmodule

// File: tb/gpio_owner_mux_tb_top.sv
`timescale 1ns/1ps
module gpio_owner_mux_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = 8'h70;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] rd_data;
    logic [17:0] src_dir;
    logic [17:0] src_val;
    logic [5:0]  pad_in = '0;
    logic [5:0]  pad_oe, pad_out;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    gpio_owner_mux dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .rd_data(rd_data), .src_dir(src_dir),
        .src_val(src_val), .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out)
    );

    // Entry: {req, wdata[15:0], exp_oe[5:0], exp_out[5:0]}
    // Sources: A dir 101010 val 111111; B dir 000111 val 010101; C dir 111111 val 110011
    localparam int NV = 10;
    localparam logic [35:0] VEC [NV] = '{
        {8'd7, 16'h000B, 6'b000011, 6'b000001},  // R7
        {8'd4, 16'h0FFF, 6'b111111, 6'b111111},  // R4
        {8'd4, 16'h0AAA, 6'b111111, 6'b000000},  // R4
        {8'd5, 16'h0555, 6'b000000, 6'b000000},  // R5
        {8'd3, 16'h1000, 6'b101010, 6'b101010},  // R3
        {8'd6, 16'h1FFF, 6'b101010, 6'b101010},  // R6
        {8'd3, 16'h2000, 6'b000111, 6'b000101},  // R3
        {8'd3, 16'h3ABC, 6'b111111, 6'b110011},  // R3
        {8'd9, 16'hC00B, 6'b000011, 6'b000001},  // R9
        {8'd4, 16'h0000, 6'b000000, 6'b000000}   // R4
    };

    task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic write_word(input logic [7:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
        bus_addr  = 8'h70;
    endtask

    initial begin
        #1000000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        src_dir = {6'b111111, 6'b000111, 6'b101010};
        src_val = {6'b110011, 6'b010101, 6'b111111};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 oe", 16'(pad_oe), 16'h0);
        check("R1 out", 16'(pad_out), 16'h0);
        check("R8 rd after reset", rd_data, 16'h0);

        for (int i = 0; i < NV; i++) begin
            write_word(8'h70, VEC[i][27:12]);
            check($sformatf("R%0d oe vec%0d", VEC[i][35:28], i), 16'(pad_oe), 16'(VEC[i][11:6]));
            check($sformatf("R%0d out vec%0d", VEC[i][35:28], i), 16'(pad_out), 16'(VEC[i][5:0]));
        end

        // R2: write to another address ignored
        write_word(8'h70, 16'h000B);
        write_word(8'h71, 16'h0FFF);
        check("R2 stray oe", 16'(pad_oe), 16'h0003);
        check("R2 stray out", 16'(pad_out), 16'h0001);

        // R8: two-edge readback latency, software mode
        @(negedge clk);
        pad_in = 6'b101101;
        @(negedge clk);
        check("R8 rd one edge", rd_data, 16'h0000);
        @(negedge clk);
        check("R8 rd two edges", rd_data, 16'h002D);
        bus_addr = 8'h12;
        #1;
        check("R8 other addr", rd_data, 16'h0000);
        bus_addr = 8'h70;

        // R8 readback under source C; R6 live source follow
        write_word(8'h70, 16'h3000);
        pad_in = 6'b010010;
        @(negedge clk);
        @(negedge clk);
        check("R8 rd src C", rd_data, 16'h0012);
        src_dir[17:12] = 6'b000001;
        #1;
        check("R6 live oe", 16'(pad_oe), 16'h0001);
        check("R5 live out", 16'(pad_out), 16'h0001);

        // R1: reset mid-run clears control
        write_word(8'h70, 16'h0FFF);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset again oe", 16'(pad_oe), 16'h0);
        check("R1 reset rd", rd_data, 16'h0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule